// File: doc/BRIEF.md
# Dual Reference Frequency Monitor

This block watches two reference clocks at once and reports, for each one, whether its frequency lies within a narrow tolerance of its programmed nominal rate. A free-running gate timer measures out a fixed window of system clock cycles. During that window, each reference is passed through its own two-flop synchroniser, and its rising edges are counted. When the window closes, each count is compared against an acceptance window computed from the selected nominal rate. The result is registered onto that channel's status flag.

Each channel has its own 2-bit rate-select code, so the two references may run at the same nominal rate or at different ones. The default gate is 250,000,000 cycles, which is 2 s at 125 MHz. The default tolerance is 12 ppm. With these defaults, both flags are refreshed once every two seconds. A high flag means the reference is off-frequency or absent.

Top module: `dual_ref_freq_monitor`

## Requirements
- R1: While `rst_n` is low, and from its release until the first measurement period has ended, both `mon0_o` and `mon1_o` read 1.
- R2: A rate code selects the nominal edge count per period: 0 = 8 kHz, 1 = 1.544 MHz, 2 = 2.048 MHz, 3 = 19.44 MHz. The defaults give 16,000, 3,088,000, 4,096,000 and 38,880,000 counts per 2 s gate. Rising edges are counted after a two-flop synchroniser, so a reference must stay below half the system clock rate.
- R3: When a channel's count lies in the inclusive window [nom − tol, nom + tol], its flag is 0 after the period ends. Here tol = floor(nom × TOL_PPM / 1,000,000), with TOL_PPM defaulting to 12.
- R4: When a channel's count is above nom + tol or below nom − tol, its flag is 1 after the period ends.
- R5: A reference with no edges during a period sets its flag to 1 at the end of that period.
- R6: Each channel is judged only on its own reference and its own rate code. A fault on one channel never changes the other channel's flag.
- R7: Flags change only on the system clock edge that ends a period. That edge is the GATE_CYCLES-th rising edge after reset release, and every GATE_CYCLES edges after it. Between these edges the flags hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, the time base for the gate |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref0_i | input | 1 | Reference clock, channel 0 |
| ref1_i | input | 1 | Reference clock, channel 1 |
| rate0_i | input | 2 | Nominal rate code for channel 0 |
| rate1_i | input | 2 | Nominal rate code for channel 1 |
| mon0_o | output | 1 | Off-frequency flag for channel 0 (1 = out of tolerance) |
| mon1_o | output | 1 | Off-frequency flag for channel 1 (1 = out of tolerance) |

## Verification
Each flag is due on the GATE_CYCLES-th clock edge after reset release, and again every GATE_CYCLES edges after that. The bench counts edges from the release and samples 2 ns after each such edge. It changes stimulus only at that sampling point. It then lets one full settling period pass before checking, so that no count mixes old and new rates. The hold requirement is checked one edge before a boundary, where the old value must still show. The boundary edge that follows must then carry the new result.

// File: rtl/refmon_pkg.sv
`timescale 1ns/1ps
package refmon_pkg;

  localparam longint unsigned PPM_SCALE = 64'd1_000_000;

  typedef enum logic [1:0] {
    RATE_8K    = 2'd0,
    RATE_T1    = 2'd1,
    RATE_E1    = 2'd2,
    RATE_SONET = 2'd3
  } rate_sel_e;

  // Tolerance in counts for a nominal count and a ppm limit (floored).
  function automatic longint unsigned tol_count(input longint unsigned nom,
                                                input longint unsigned ppm);
    return (nom * ppm) / PPM_SCALE;
  endfunction

endpackage

// File: rtl/refmon_gate_timer.sv
`timescale 1ns/1ps
module refmon_gate_timer #(
  parameter int unsigned GATE_CYCLES = 250_000_000,
  localparam int unsigned CW = $clog2(GATE_CYCLES)
) (
  input  logic clk,
  input  logic rst_n,
  output logic gate_end_o
);
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    gate_end_o = (cnt_q == CW'(GATE_CYCLES - 1));
    cnt_d      = gate_end_o ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/refmon_edge_counter.sv
`timescale 1ns/1ps
module refmon_edge_counter #(
  parameter int unsigned CNT_W = 28
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_i,
  input  logic             gate_end_i,
  output logic [CNT_W-1:0] total_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [2:0]       sync_q, sync_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             rise;

  always_comb begin
    sync_d  = {sync_q[1:0], ref_i};
    rise    = sync_q[1] & ~sync_q[2];
    total_o = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + CNT_W'(rise);
    cnt_d   = gate_end_i ? '0 : total_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      cnt_q  <= '0;
    end else begin
      sync_q <= sync_d;
      cnt_q  <= cnt_d;
    end
  end
endmodule

// File: rtl/refmon_window_check.sv
`timescale 1ns/1ps
module refmon_window_check
  import refmon_pkg::*;
#(
  parameter int unsigned CNT_W     = 28,
  parameter int unsigned NOM_8K    = 16_000,
  parameter int unsigned NOM_T1    = 3_088_000,
  parameter int unsigned NOM_E1    = 4_096_000,
  parameter int unsigned NOM_SONET = 38_880_000,
  parameter int unsigned TOL_PPM   = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             gate_end_i,
  input  logic [1:0]       rate_i,
  input  logic [CNT_W-1:0] total_i,
  output logic             mon_o
);
  localparam longint unsigned TOL0 = tol_count(64'(NOM_8K),    64'(TOL_PPM));
  localparam longint unsigned TOL1 = tol_count(64'(NOM_T1),    64'(TOL_PPM));
  localparam longint unsigned TOL2 = tol_count(64'(NOM_E1),    64'(TOL_PPM));
  localparam longint unsigned TOL3 = tol_count(64'(NOM_SONET), 64'(TOL_PPM));

  longint unsigned lo, hi, cnt64;
  logic            bad, mon_q, mon_d;

  always_comb begin
    case (rate_sel_e'(rate_i))
      RATE_8K:    begin lo = 64'(NOM_8K)    - TOL0; hi = 64'(NOM_8K)    + TOL0; end
      RATE_T1:    begin lo = 64'(NOM_T1)    - TOL1; hi = 64'(NOM_T1)    + TOL1; end
      RATE_E1:    begin lo = 64'(NOM_E1)    - TOL2; hi = 64'(NOM_E1)    + TOL2; end
      default:    begin lo = 64'(NOM_SONET) - TOL3; hi = 64'(NOM_SONET) + TOL3; end
    endcase
    cnt64 = 64'(total_i);
    bad   = (cnt64 < lo) || (cnt64 > hi);
    mon_d = gate_end_i ? bad : mon_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mon_q <= 1'b1;
    else        mon_q <= mon_d;
  end

  assign mon_o = mon_q;
endmodule

// File: rtl/dual_ref_freq_monitor.sv
`timescale 1ns/1ps
module dual_ref_freq_monitor #(
  parameter int unsigned GATE_CYCLES = 250_000_000,
  parameter int unsigned NOM_8K      = 16_000,
  parameter int unsigned NOM_T1      = 3_088_000,
  parameter int unsigned NOM_E1      = 4_096_000,
  parameter int unsigned NOM_SONET   = 38_880_000,
  parameter int unsigned TOL_PPM     = 12
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ref0_i,
  input  logic       ref1_i,
  input  logic [1:0] rate0_i,
  input  logic [1:0] rate1_i,
  output logic       mon0_o,
  output logic       mon1_o
);
  localparam int unsigned NCH   = 2;
  localparam int unsigned CNT_W = $clog2(GATE_CYCLES + 1);

  logic             gate_end;
  logic [NCH-1:0]   ref_vec;
  logic [NCH-1:0]   mon_vec;
  logic [1:0]       rate_vec [NCH];

  assign ref_vec     = {ref1_i, ref0_i};
  assign rate_vec[0] = rate0_i;
  assign rate_vec[1] = rate1_i;

  refmon_gate_timer #(.GATE_CYCLES(GATE_CYCLES)) u_gate (
    .clk        (clk),
    .rst_n      (rst_n),
    .gate_end_o (gate_end)
  );

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    logic [CNT_W-1:0] total;

    refmon_edge_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk        (clk),
      .rst_n      (rst_n),
      .ref_i      (ref_vec[ch]),
      .gate_end_i (gate_end),
      .total_o    (total)
    );

    refmon_window_check #(
      .CNT_W     (CNT_W),
      .NOM_8K    (NOM_8K),
      .NOM_T1    (NOM_T1),
      .NOM_E1    (NOM_E1),
      .NOM_SONET (NOM_SONET),
      .TOL_PPM   (TOL_PPM)
    ) u_win (
      .clk        (clk),
      .rst_n      (rst_n),
      .gate_end_i (gate_end),
      .rate_i     (rate_vec[ch]),
      .total_i    (total),
      .mon_o      (mon_vec[ch])
    );
  end

  assign mon0_o = mon_vec[0];
  assign mon1_o = mon_vec[1];
endmodule

// File: rtl/refmon_checker.sv
`timescale 1ns/1ps
module refmon_checker #(
  parameter int unsigned GATE_CYCLES = 250_000_000,
  localparam int unsigned CW = $clog2(GATE_CYCLES)
) (
  input logic clk,
  input logic rst_n,
  input logic ref0_i,
  input logic ref1_i,
  input logic mon0_o,
  input logic mon1_o
);
  logic [CW-1:0] per_q;
  logic          at_end, first_done_q, past_ok_q, end_seen_q;
  logic          r0_q, r1_q, act0_q, act1_q, act0_now, act1_now;

  assign at_end   = (per_q == CW'(GATE_CYCLES - 1));
  assign act0_now = act0_q | (ref0_i != r0_q);
  assign act1_now = act1_q | (ref1_i != r1_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_q <= '0; first_done_q <= 1'b0; past_ok_q <= 1'b0; end_seen_q <= 1'b0;
      r0_q <= 1'b0; r1_q <= 1'b0; act0_q <= 1'b1; act1_q <= 1'b1;
    end else begin
      per_q        <= at_end ? '0 : per_q + 1'b1;
      first_done_q <= first_done_q | at_end;
      past_ok_q    <= 1'b1;
      end_seen_q   <= at_end;
      r0_q         <= ref0_i;
      r1_q         <= ref1_i;
      act0_q       <= at_end ? 1'b0 : act0_now;
      act1_q       <= at_end ? 1'b0 : act1_now;
    end
  end

  // R1: flags high until the first period completes
  assert_reset_flags_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !first_done_q |-> (mon0_o && mon1_o));

  // R7: flags hold except on the edge that closes a period
  assert_hold_between_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok_q && !end_seen_q) |-> ($stable(mon0_o) && $stable(mon1_o)));

  // R5: a silent reference channel 0 is flagged
  assert_dead_ref0_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (at_end && first_done_q && !act0_now) |=> mon0_o);

  // R5 / R6: a silent reference channel 1 is flagged on its own flag
  assert_dead_ref1_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (at_end && first_done_q && !act1_now) |=> mon1_o);

  // R3: flags always carry a defined level
  assert_flags_known_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$isunknown({mon0_o, mon1_o}));
endmodule

bind dual_ref_freq_monitor refmon_checker #(.GATE_CYCLES(GATE_CYCLES)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .ref0_i (ref0_i),
  .ref1_i (ref1_i),
  .mon0_o (mon0_o),
  .mon1_o (mon1_o)
);

// File: tb/dual_ref_freq_monitor_tb.sv
`timescale 1ns/1ps
module dual_ref_freq_monitor_tb;
  localparam int G = 4000;            // gate: 4000 cycles = 32 us
  localparam real HALF_SCALE = 16000.0; // half period (ns) = 16000 / count
  // nominal counts: code0 100, code1 200, code2 400, code3 500; 2% -> tol 2,4,8,10

  logic clk = 1'b0, rst_n = 1'b0;
  logic ref0 = 1'b0, ref1 = 1'b0;
  logic [1:0] rate0 = 2'd0, rate1 = 2'd0;
  logic mon0, mon1;
  real hp0 = 160.0, hp1 = 160.0;
  int n_tests = 0, n_fail = 0;
  bit  done = 1'b0;

  always #4 clk = ~clk;

  always begin
    if (hp0 > 0.0) begin #(hp0); ref0 = ~ref0; end
    else #8;
  end
  always begin
    if (hp1 > 0.0) begin #(hp1); ref1 = ~ref1; end
    else #8;
  end

  dual_ref_freq_monitor #(
    .GATE_CYCLES(G), .NOM_8K(100), .NOM_T1(200), .NOM_E1(400),
    .NOM_SONET(500), .TOL_PPM(20000)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .ref0_i(ref0), .ref1_i(ref1),
    .rate0_i(rate0), .rate1_i(rate1), .mon0_o(mon0), .mon1_o(mon1)
  );

  task automatic check(input string req, input logic got, input logic exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0b expected %0b at %0t", req, got, exp, $time);
    end
  endtask

  function automatic real half_of(input int n);
    return (n == 0) ? 0.0 : HALF_SCALE / real'(n);
  endfunction

  // columns: rate0, count0, rate1, count1, exp0, exp1
  localparam int NV = 12;
  localparam int VEC [NV][6] = '{
    '{0, 100, 0, 100, 0, 0},  // R3 R2 nominal, same rate on both
    '{1, 200, 2, 400, 0, 0},  // R3 R2 different rates
    '{3, 500, 0, 100, 0, 0},  // R3 R2 fastest code
    '{0, 106, 1, 200, 1, 0},  // R4 R6 ch0 high, ch1 unaffected
    '{0,  94, 1, 190, 1, 1},  // R4 both low
    '{2, 400, 3, 520, 0, 1},  // R4 R6 ch1 high only
    '{2, 415, 3, 480, 1, 1},  // R4 above and below
    '{1, 202, 3, 508, 0, 0},  // R3 near upper limit
    '{0,  99, 2, 393, 0, 0},  // R3 near lower limit
    '{3, 100, 0, 500, 1, 1},  // R2 code swapped against rate
    '{0,   0, 1, 200, 1, 0},  // R5 R6 ch0 silent
    '{0, 100, 3,   0, 0, 1}   // R5 R6 ch1 silent
  };

  initial begin
    #1_500_000;
    if (!done) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (5) @(posedge clk);
    @(negedge clk);
    check("R1 in reset ch0", mon0, 1'b1);
    rst_n = 1'b1;
    repeat (G - 1) @(posedge clk);
    #2;
    check("R1 before first period ch0", mon0, 1'b1);
    check("R1 before first period ch1", mon1, 1'b1);
    @(posedge clk);
    #2;
    check("R7 first update ch0", mon0, 1'b0);
    check("R7 first update ch1", mon1, 1'b0);

    for (int v = 0; v < NV; v++) begin
      rate0 = 2'(VEC[v][0]); hp0 = half_of(VEC[v][1]);
      rate1 = 2'(VEC[v][2]); hp1 = half_of(VEC[v][3]);
      repeat (2 * G) @(posedge clk);
      #2;
      check($sformatf("vector %0d ch0", v), mon0, 1'(VEC[v][4]));
      check($sformatf("vector %0d ch1", v), mon1, 1'(VEC[v][5]));
    end

    // R7: a fault seen mid-period shows only at the closing edge
    rate0 = 2'd0; hp0 = half_of(100); rate1 = 2'd1; hp1 = half_of(200);
    repeat (2 * G) @(posedge clk);
    #2;
    check("R3 settle ch0", mon0, 1'b0);
    hp0 = half_of(110);
    repeat (G - 1) @(posedge clk);
    #2;
    check("R7 hold before boundary", mon0, 1'b0);
    @(posedge clk);
    #2;
    check("R4 update at boundary", mon0, 1'b1);
    check("R6 other channel held low", mon1, 1'b0);

    // R1: reset mid-run forces both flags high
    hp0 = half_of(100);
    repeat (G / 2) @(posedge clk);
    #2;
    rst_n = 1'b0;
    #10;
    check("R1 async reset ch0", mon0, 1'b1);
    check("R1 async reset ch1", mon1, 1'b1);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (G - 1) @(posedge clk);
    #2;
    check("R1 after re-release ch1", mon1, 1'b1);
    @(posedge clk);
    #2;
    check("R3 after re-release ch0", mon0, 1'b0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule